// File: doc/BRIEF.md
# Signed-Amount Shift and Rotate Unit with Weight Count

This unit is the shift and rotate stage of a small 16-bit CPU datapath. Each accepted request carries an operand, a signed 5-bit shift amount, an operation group, a nominal direction, the current carry and extend bits, and a weight-mode flag. The unit applies one of four operation groups: arithmetic shift, logical shift, plain rotate, and rotate through the extend bit. The sign of the amount can reverse the nominal direction. The unit returns a 16-bit result, a carry-out and an updated extend bit.

In weight mode the shift still runs as requested. The unit counts how many one-bits left the word through bit 0, and it returns that count in place of the shifted value. The carry and extend outputs follow the shift exactly as they do in normal mode.

The whole operation fits in one clock. Each result appears on a registered output one cycle after its request. Requests can be issued on every cycle.

Top module: `shiftrot_unit`

## Requirements
- R1: A request presented with `in_valid` high at a rising clock edge produces `out_valid` high, with its result, after the next rising edge. A cycle with `in_valid` low produces `out_valid` low after the next edge.
- R2: `in_amount` is a 5-bit two's complement value from -16 to +15. `in_right` = 0 names a left operation and 1 names a right operation. A negative amount reverses the named direction and shifts by the magnitude, so left by -3 equals right by 3.
- R3: Operation code 2'b00 is arithmetic. A right shift copies bit 15 into the vacated high positions, and a left shift fills bit 0 with zero.
- R4: Operation code 2'b01 is logical. Vacated positions are filled with zero in both directions.
- R5: Operation code 2'b10 is plain rotate. A bit leaving one end re-enters at the other end.
- R6: Operation code 2'b11 rotates through the extend bit as a 17-bit ring, with `in_xbit` as the 17th bit. `out_xbit` equals the last bit shifted out.
- R7: `out_carry` is the last bit shifted out of the word. With an amount of zero, `out_carry` equals `in_carry`, `out_xbit` equals `in_xbit`, and the operand passes through unchanged.
- R8: For operation codes 2'b00, 2'b01 and 2'b10, `out_xbit` equals `in_xbit`.
- R9: With `in_weight` high, `out_result` is the number of one-bits that exited at bit 0 during an effective right shift, zero-extended to 16 bits. An effective left shift gives 0. Carry and extend behave as in normal mode.
- R10: While `in_valid` is low, `out_result`, `out_carry` and `out_xbit` hold their previous values whatever the other inputs do.
- R11: After reset, `out_valid`, `out_result`, `out_carry` and `out_xbit` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| in_operand | input | 16 | Value to shift or rotate |
| in_amount | input | 5 | Signed shift amount, -16..+15 |
| in_op | input | 2 | Operation group: 00 arith, 01 logical, 10 rotate, 11 rotate via extend |
| in_right | input | 1 | Named direction: 0 left, 1 right |
| in_carry | input | 1 | Current carry bit, kept for a zero amount |
| in_xbit | input | 1 | Current extend bit |
| in_weight | input | 1 | Return a one-bit count instead of the result |
| out_valid | output | 1 | Result strobe |
| out_result | output | 16 | Shifted value or weight count |
| out_carry | output | 1 | Last bit shifted out |
| out_xbit | output | 1 | Updated extend bit |

## Verification
The assertions check the cycle-level properties on every cycle: the one-cycle valid pipeline, holding during idle cycles, carry and extend passing through for a zero amount, an unchanged extend bit outside the extend-rotate group, the bound on the weight count, zero weight for effective left shifts, and the number of ones being preserved by a plain rotate. Bit-exact results can only be shown by the bench scenarios. These include the fill values of each group, the 17-bit ring of the extend rotate, direction reversal at -16, and the exact count in weight mode. The bench compares every group, both named directions and all 32 amounts, with weight mode on and off, against a bit-serial model.

// File: rtl/shiftrot_pkg.sv
package shiftrot_pkg;

    typedef enum logic [1:0] {
        OP_ARITH = 2'b00,
        OP_LOGIC = 2'b01,
        OP_ROT   = 2'b10,
        OP_ROTX  = 2'b11
    } shop_e;

endpackage

// File: rtl/shiftrot_decode.sv
// Turns the signed amount and the named direction into an effective
// direction and an unsigned step count.
module shiftrot_decode #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] amount,
    input  logic          right_named,
    output logic          right_eff,
    output logic [AW-1:0] magnitude
);
    logic negative;

    always_comb begin
        negative  = amount[AW-1];
        magnitude = negative ? (~amount + AW'(1)) : amount;
        right_eff = right_named ^ negative;
    end
endmodule

// File: rtl/shiftrot_step.sv
// One position of movement; passes everything through when not enabled.
module shiftrot_step
    import shiftrot_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = 5
) (
    input  logic          en,
    input  logic          right,
    input  shop_e         op,
    input  logic [W-1:0]  v_i,
    input  logic          x_i,
    input  logic          c_i,
    input  logic [CW-1:0] n_i,
    output logic [W-1:0]  v_o,
    output logic          x_o,
    output logic          c_o,
    output logic [CW-1:0] n_o
);
    logic lost;
    logic fill;

    always_comb begin
        lost = 1'b0;
        fill = 1'b0;
        v_o  = v_i;
        x_o  = x_i;
        c_o  = c_i;
        n_o  = n_i;
        if (en) begin
            if (right) begin
                lost = v_i[0];
                unique case (op)
                    OP_ARITH: fill = v_i[W-1];
                    OP_LOGIC: fill = 1'b0;
                    OP_ROT:   fill = v_i[0];
                    OP_ROTX:  fill = x_i;
                endcase
                v_o = {fill, v_i[W-1:1]};
                n_o = n_i + CW'(lost);
            end else begin
                lost = v_i[W-1];
                unique case (op)
                    OP_ARITH: fill = 1'b0;
                    OP_LOGIC: fill = 1'b0;
                    OP_ROT:   fill = v_i[W-1];
                    OP_ROTX:  fill = x_i;
                endcase
                v_o = {v_i[W-2:0], fill};
            end
            c_o = lost;
            if (op == OP_ROTX) begin
                x_o = lost;
            end
        end
    end
endmodule

// File: rtl/shiftrot_chain.sv
// Unrolled chain of single-position steps; stage k acts when k < magnitude.
module shiftrot_chain
    import shiftrot_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 5,
    parameter int CW = 5
) (
    input  logic [W-1:0]  operand,
    input  logic [AW-1:0] magnitude,
    input  logic          right,
    input  shop_e         op,
    input  logic          carry_in,
    input  logic          xbit_in,
    output logic [W-1:0]  value,
    output logic          carry_out,
    output logic          xbit_out,
    output logic [CW-1:0] count
);
    localparam int STEPS = 2 ** (AW - 1);

    logic [W-1:0]  v_w [STEPS+1];
    logic          x_w [STEPS+1];
    logic          c_w [STEPS+1];
    logic [CW-1:0] n_w [STEPS+1];

    assign v_w[0] = operand;
    assign x_w[0] = xbit_in;
    assign c_w[0] = carry_in;
    assign n_w[0] = '0;

    for (genvar k = 0; k < STEPS; k++) begin : g_stage
        logic act;
        assign act = (magnitude > AW'(k));
        shiftrot_step #(.W(W), .CW(CW)) u_step (
            .en    (act),
            .right (right),
            .op    (op),
            .v_i   (v_w[k]),
            .x_i   (x_w[k]),
            .c_i   (c_w[k]),
            .n_i   (n_w[k]),
            .v_o   (v_w[k+1]),
            .x_o   (x_w[k+1]),
            .c_o   (c_w[k+1]),
            .n_o   (n_w[k+1])
        );
    end

    assign value     = v_w[STEPS];
    assign carry_out = c_w[STEPS];
    assign xbit_out  = x_w[STEPS];
    assign count     = n_w[STEPS];
endmodule

// File: rtl/shiftrot_unit.sv
module shiftrot_unit
    import shiftrot_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  in_operand,
    input  logic [AW-1:0] in_amount,
    input  logic [1:0]    in_op,
    input  logic          in_right,
    input  logic          in_carry,
    input  logic          in_xbit,
    input  logic          in_weight,
    output logic          out_valid,
    output logic [W-1:0]  out_result,
    output logic          out_carry,
    output logic          out_xbit
);
    localparam int STEPS = 2 ** (AW - 1);
    localparam int CW    = $clog2(STEPS + 1);

    typedef struct packed {
        logic         valid;
        logic [W-1:0] result;
        logic         carry;
        logic         xbit;
    } out_t;

    out_t out_d, out_q;

    logic          right_eff;
    logic [AW-1:0] magnitude;
    logic [W-1:0]  moved;
    logic          carry_new;
    logic          xbit_new;
    logic [CW-1:0] weight_cnt;

    shiftrot_decode #(.AW(AW)) u_decode (
        .amount      (in_amount),
        .right_named (in_right),
        .right_eff   (right_eff),
        .magnitude   (magnitude)
    );

    shiftrot_chain #(.W(W), .AW(AW), .CW(CW)) u_chain (
        .operand   (in_operand),
        .magnitude (magnitude),
        .right     (right_eff),
        .op        (shop_e'(in_op)),
        .carry_in  (in_carry),
        .xbit_in   (in_xbit),
        .value     (moved),
        .carry_out (carry_new),
        .xbit_out  (xbit_new),
        .count     (weight_cnt)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = in_valid;
        if (in_valid) begin
            out_d.result = in_weight ? {{(W-CW){1'b0}}, weight_cnt} : moved;
            out_d.carry  = carry_new;
            out_d.xbit   = xbit_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid  = out_q.valid;
    assign out_result = out_q.result;
    assign out_carry  = out_q.carry;
    assign out_xbit   = out_q.xbit;
endmodule

// File: rtl/shiftrot_unit_chk.sv
module shiftrot_unit_chk #(
    parameter int W  = 16,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [W-1:0]  in_operand,
    input logic [AW-1:0] in_amount,
    input logic [1:0]    in_op,
    input logic          in_right,
    input logic          in_carry,
    input logic          in_xbit,
    input logic          in_weight,
    input logic          out_valid,
    input logic [W-1:0]  out_result,
    input logic          out_carry,
    input logic          out_xbit
);
    localparam int STEPS = 2 ** (AW - 1);

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_carry) && $stable(out_xbit)));

    assert_zero_amount_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_amount == '0) |=>
            (out_carry == $past(in_carry) && out_xbit == $past(in_xbit)));

    assert_xbit_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op != 2'b11) |=> (out_xbit == $past(in_xbit)));

    assert_weight_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_weight) |=> (out_result <= W'(STEPS)));

    assert_weight_left_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_weight && (in_right == in_amount[AW-1])) |=> (out_result == '0));

    assert_rotate_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_weight && in_op == 2'b10) |=>
            ($countones(out_result) == $countones($past(in_operand))));
endmodule

bind shiftrot_unit shiftrot_unit_chk #(.W(W), .AW(AW)) u_chk (.*);

// File: tb/shiftrot_unit_bench.sv
module shiftrot_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    typedef struct {
        logic [15:0] result;
        logic        carry;
        logic        xbit;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_operand = '0;
    logic [4:0]  in_amount = '0;
    logic [1:0]  in_op = '0;
    logic        in_right = 1'b0;
    logic        in_carry = 1'b0;
    logic        in_xbit = 1'b0;
    logic        in_weight = 1'b0;
    logic        out_valid;
    logic [15:0] out_result;
    logic        out_carry;
    logic        out_xbit;

    int   checks = 0;
    int   errors = 0;
    bit   reported = 1'b0;
    exp_t sb_q[$];
    exp_t last_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    shiftrot_unit u_shiftrot_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_operand (in_operand),
        .in_amount  (in_amount),
        .in_op      (in_op),
        .in_right   (in_right),
        .in_carry   (in_carry),
        .in_xbit    (in_xbit),
        .in_weight  (in_weight),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_carry  (out_carry),
        .out_xbit   (out_xbit)
    );

    // Bit-serial model written from the requirements.
    function automatic exp_t model(input logic [15:0] v, input logic [4:0] amt,
                                   input logic [1:0] op, input logic right_named,
                                   input logic c, input logic x, input logic wt);
        exp_t e;
        int   mag;
        logic go_right;
        int   ones;
        logic b;
        mag      = ($signed(amt) < 0) ? -int'($signed(amt)) : int'($signed(amt));
        go_right = right_named ^ ($signed(amt) < 0);
        ones     = 0;
        for (int i = 0; i < mag; i++) begin
            if (go_right) begin
                b = v[0];
                ones += int'(b);
                case (op)
                    2'b00: v = {v[15], v[15:1]};
                    2'b01: v = {1'b0, v[15:1]};
                    2'b10: v = {b, v[15:1]};
                    default: v = {x, v[15:1]};
                endcase
            end else begin
                b = v[15];
                case (op)
                    2'b00, 2'b01: v = {v[14:0], 1'b0};
                    2'b10: v = {v[14:0], b};
                    default: v = {v[14:0], x};
                endcase
            end
            c = b;
            if (op == 2'b11) x = b;
        end
        e.result = wt ? 16'(ones) : v;
        e.carry  = c;
        e.xbit   = x;
        if (wt)              e.tag = "R9";
        else if (mag == 0)   e.tag = "R7";
        else if (op == 2'b00) e.tag = "R3";
        else if (op == 2'b01) e.tag = "R4";
        else if (op == 2'b10) e.tag = "R5";
        else                 e.tag = "R6";
        return e;
    endfunction

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic drive(input logic [15:0] v, input logic [4:0] amt, input logic [1:0] op,
                         input logic rn, input logic c, input logic x, input logic wt);
        exp_t e;
        in_valid   = 1'b1;
        in_operand = v;
        in_amount  = amt;
        in_op      = op;
        in_right   = rn;
        in_carry   = c;
        in_xbit    = x;
        in_weight  = wt;
        e = model(v, amt, op, rn, c, x, wt);
        sb_q.push_back(e);
        last_exp = e;
        @(negedge clk);
    endtask

    // Monitor: pops one expected item per valid result (R1 timing).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (sb_q.size() == 0) begin
                    check("R1", {out_result, out_carry, out_xbit}, 18'h0);
                    errors += (checks > 0 && errors == 0) ? 1 : 0;
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(e.tag, {out_result, out_carry, out_xbit},
                          {e.result, e.carry, e.xbit});
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        report();
    end

    initial begin
        logic [15:0] pats [3];
        pats[0] = 16'h8001;
        pats[1] = 16'hB5C3;
        pats[2] = 16'h4E72;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", {out_result, out_carry, out_xbit}, 18'h0);
        check("R11", {17'h0, out_valid}, 18'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 R3 R4 R5 R6 R7 R8 R9: all groups, directions, amounts, weight modes
        for (int op = 0; op < 4; op++) begin
            for (int rn = 0; rn < 2; rn++) begin
                for (int a = -16; a < 16; a++) begin
                    for (int wt = 0; wt < 2; wt++) begin
                        for (int p = 0; p < 3; p++) begin
                            for (int x = 0; x < 2; x++) begin
                                drive(pats[p], 5'(a), 2'(op), 1'(rn), 1'(p[0] ^ x[0]),
                                      1'(x), 1'(wt));
                            end
                        end
                    end
                end
            end
        end
        // R2: left by -3 equals right by 3 on a fixed value
        drive(16'hF00D, 5'h1D, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
        if (last_exp.result !== 16'h1E01) check("R2", {last_exp.result, 2'b00}, {16'h1E01, 2'b00});
        // R10: idle cycles with changing inputs must not disturb outputs
        in_valid   = 1'b0;
        in_operand = 16'hFFFF;
        in_amount  = 5'h07;
        in_op      = 2'b11;
        in_carry   = ~last_exp.carry;
        in_xbit    = ~last_exp.xbit;
        in_weight  = 1'b0;
        repeat (3) @(negedge clk);
        check("R10", {out_result, out_carry, out_xbit},
              {last_exp.result, last_exp.carry, last_exp.xbit});
        check("R1", {17'h0, out_valid}, 18'h0);
        check("R1", 18'(sb_q.size()), 18'h0);
        report();
    end
endmodule